// File: doc/BRIEF.md
# Link-Side Packet Receive Framer

This block sits on the link side of a PHY-link interface. It watches a 2-bit control bus and an 8-bit data bus, both driven by the PHY and sampled on the interface clock. When the control bus signals a receive, the PHY first drives all-ones bytes. It then sends a single in-band speed-code byte, followed by the packet bytes. The packet ends when the control bus returns to idle.

The framer strips the all-ones lead-in and the speed code. It reports the speed code on a separate strobed output and checks it against the fixed backplane value when backplane mode is selected. The payload goes out as a byte stream with valid, first and last markers. Because the end of a packet is known only one clock after its final byte, every payload byte is held for one sample and then registered out. Two further conditions are flagged with one-cycle pulses: a packet with no bytes, and a control code that breaks off a transfer.

Top module: `lrx_frame_top`

## Requirements
- R1: After a synchronous active-low reset, the outputs spd_vld, spd_err, pay_vld, pay_first, pay_last, empty_err and proto_err are all 0.
- R2: While phy_ctl is 2'b10 (receive) and no speed code has been taken yet, data bytes equal to 8'hFF produce no payload and no speed strobe.
- R3: The first non-8'hFF byte sampled under receive is the speed code. spd_vld is 1 for exactly one cycle, in the cycle after the edge that sampled it, and spd_code holds that byte. The byte never appears on pay_data.
- R4: spd_err is raised together with spd_vld when bp_mode is 1 and bits [7:6] of the speed code are not 2'b00. It stays 0 when bp_mode is 0.
- R5: Each byte sampled under receive after the speed code, including 8'hFF, is output once and in order on pay_data with pay_vld = 1. A byte appears in the cycle after the edge that samples the next control/data pair.
- R6: pay_first is 1 on the first payload byte of a packet only.
- R7: phy_ctl = 2'b00 (idle) after at least one payload byte ends the packet. The last byte is then output with pay_last = 1 in the cycle after the idle sample.
- R8: Idle sampled directly after the speed code gives a one-cycle empty_err pulse and no pay_vld.
- R9: phy_ctl = 2'b01 or 2'b11 during a receive, or idle before any speed code, gives a one-cycle proto_err pulse. Any byte not yet output is dropped without pay_last, and the block waits for a new receive.
- R10: While waiting for a receive, phy_ctl values other than 2'b10 produce no output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_mode | input | 1 | Backplane mode: enables the speed-code check |
| phy_ctl | input | 2 | Control bus from PHY (00 idle, 10 receive) |
| phy_dat | input | 8 | Data bus from PHY |
| spd_vld | output | 1 | Speed code strobe |
| spd_code | output | 8 | Captured speed-code byte |
| spd_err | output | 1 | Speed code invalid in backplane mode |
| pay_vld | output | 1 | Payload byte valid |
| pay_data | output | 8 | Payload byte |
| pay_first | output | 1 | First byte of packet |
| pay_last | output | 1 | Last byte of packet |
| empty_err | output | 1 | Packet ended with no payload bytes |
| proto_err | output | 1 | Transfer broken off by an illegal control code |

## Verification
A sequencer stuck in the lead-in state would swallow the speed code: the missing spd_vld and the missing payload show up one cycle after the speed byte. A lost hold-register valid bit shows up within one cycle, either as a dropped or doubled byte, as pay_last missing at the idle sample, or as empty_err firing on a non-empty packet. The directed tests check strobe timing to the exact cycle, and check the whole byte stream with its markers for every packet shape.

// File: rtl/lrx_pkg.sv
// Shared constants and types for the link-side receive framer.
// Assumes a 2-bit control bus whose code 2'b10 means receive and 2'b00 idle.
package lrx_pkg;
    localparam int CTL_W = 2;
    localparam logic [CTL_W-1:0] CTL_IDLE = 2'b00;
    localparam logic [CTL_W-1:0] CTL_RECV = 2'b10;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,  // waiting for a receive
        ST_LEAD = 2'd1,  // receive seen, all-ones lead-in bytes
        ST_BODY = 2'd2   // speed code taken, payload bytes flowing
    } lrx_state_e;
endpackage

// File: rtl/lrx_ctl_decode.sv
// Decodes the PHY control bus into idle, receive and other classes.
// Assumes the bus is already synchronous to clk.
module lrx_ctl_decode
    import lrx_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output logic             is_idle,
    output logic             is_recv,
    output logic             is_other
);
    // Classify the current control code.
    always_comb begin
        is_idle  = (ctl == CTL_IDLE);
        is_recv  = (ctl == CTL_RECV);
        is_other = !is_idle && !is_recv;
    end
endmodule

// File: rtl/lrx_seq.sv
// Receive sequencer: tracks lead-in, speed code and payload phases.
// Issues take/flush/abort commands to the output stage and registers
// the speed strobe and the error pulses. Assumes the output stage
// reports through hold_v whether a payload byte is being held.
module lrx_seq
    import lrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SPD_CHK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bp_mode,
    input  logic              is_idle,
    input  logic              is_recv,
    input  logic              is_other,
    input  logic [DATA_W-1:0] dat,
    input  logic              hold_v,
    output logic              take,
    output logic              flush,
    output logic              abort,
    output logic              spd_vld,
    output logic [DATA_W-1:0] spd_code,
    output logic              spd_err,
    output logic              empty_err,
    output logic              proto_err
);
    localparam logic [DATA_W-1:0] LEAD_BYTE = '1;

    lrx_state_e state, nxt;
    logic       spd_cap, empty_hit, proto_hit, lead;

    // Next-state and command decode for the current sample.
    always_comb begin
        nxt       = state;
        take      = 1'b0;
        flush     = 1'b0;
        abort     = 1'b0;
        spd_cap   = 1'b0;
        empty_hit = 1'b0;
        proto_hit = 1'b0;
        lead      = (dat == LEAD_BYTE);
        unique case (state)
            ST_WAIT: begin
                if (is_recv) begin
                    if (lead) nxt = ST_LEAD;
                    else begin spd_cap = 1'b1; nxt = ST_BODY; end
                end
            end
            ST_LEAD: begin
                if (is_recv) begin
                    if (!lead) begin spd_cap = 1'b1; nxt = ST_BODY; end
                end else begin
                    proto_hit = 1'b1;
                    nxt       = ST_WAIT;
                end
            end
            ST_BODY: begin
                if (is_recv) begin
                    take = 1'b1;
                end else if (is_idle) begin
                    if (hold_v) flush = 1'b1;
                    else empty_hit = 1'b1;
                    nxt = ST_WAIT;
                end else if (is_other) begin
                    abort     = 1'b1;
                    proto_hit = 1'b1;
                    nxt       = ST_WAIT;
                end
            end
            default: nxt = ST_WAIT;
        endcase
    end

    // State register and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_WAIT;
            spd_vld   <= 1'b0;
            spd_code  <= '0;
            spd_err   <= 1'b0;
            empty_err <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            state     <= nxt;
            spd_vld   <= spd_cap;
            if (spd_cap) spd_code <= dat;
            spd_err   <= spd_cap && bp_mode && (|dat[DATA_W-1 -: SPD_CHK_W]);
            empty_err <= empty_hit;
            proto_err <= proto_hit;
        end
    end

    AST_SPD_ERR_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        spd_err |-> spd_vld);  // R4
    AST_SPD_ENTERS_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        spd_vld |-> state == ST_BODY);  // R3
    AST_PROTO_RETURNS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> state == ST_WAIT);  // R9
    AST_EMPTY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err |=> !empty_err);  // R8
endmodule

// File: rtl/lrx_out_stage.sv
// Payload output stage: holds one byte so the end of packet can be
// attached to it, then registers it out with first/last markers.
// Assumes take, flush and abort are mutually exclusive.
module lrx_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              flush,
    input  logic              abort,
    input  logic [DATA_W-1:0] dat,
    output logic              hold_v,
    output logic              pay_vld,
    output logic [DATA_W-1:0] pay_data,
    output logic              pay_first,
    output logic              pay_last
);
    logic [DATA_W-1:0] hold_d;
    logic              hold_f;

    // Hold register update and registered payload emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_d    <= '0;
            hold_f    <= 1'b0;
            pay_vld   <= 1'b0;
            pay_data  <= '0;
            pay_first <= 1'b0;
            pay_last  <= 1'b0;
        end else begin
            pay_vld   <= 1'b0;
            pay_first <= 1'b0;
            pay_last  <= 1'b0;
            if (take) begin
                if (hold_v) begin
                    pay_vld   <= 1'b1;
                    pay_data  <= hold_d;
                    pay_first <= hold_f;
                end
                hold_d <= dat;
                hold_f <= !hold_v;
                hold_v <= 1'b1;
            end else if (flush) begin
                if (hold_v) begin
                    pay_vld   <= 1'b1;
                    pay_data  <= hold_d;
                    pay_first <= hold_f;
                    pay_last  <= 1'b1;
                end
                hold_v <= 1'b0;
            end else if (abort) begin
                hold_v <= 1'b0;
            end
        end
    end

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |-> pay_vld);  // R7
    AST_FIRST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pay_first |-> pay_vld);  // R6
    AST_LAST_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |-> !hold_v);  // R7
endmodule

// File: rtl/lrx_frame_top.sv
// Top of the link-side receive framer: control decode, sequencer and
// payload output stage. Assumes PHY inputs are synchronous to clk.
module lrx_frame_top
    import lrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bp_mode,
    input  logic [CTL_W-1:0]  phy_ctl,
    input  logic [DATA_W-1:0] phy_dat,
    output logic              spd_vld,
    output logic [DATA_W-1:0] spd_code,
    output logic              spd_err,
    output logic              pay_vld,
    output logic [DATA_W-1:0] pay_data,
    output logic              pay_first,
    output logic              pay_last,
    output logic              empty_err,
    output logic              proto_err
);
    logic is_idle, is_recv, is_other;
    logic take, flush, abort, hold_v;

    lrx_ctl_decode u_dec (
        .ctl      (phy_ctl),
        .is_idle  (is_idle),
        .is_recv  (is_recv),
        .is_other (is_other)
    );

    lrx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_mode   (bp_mode),
        .is_idle   (is_idle),
        .is_recv   (is_recv),
        .is_other  (is_other),
        .dat       (phy_dat),
        .hold_v    (hold_v),
        .take      (take),
        .flush     (flush),
        .abort     (abort),
        .spd_vld   (spd_vld),
        .spd_code  (spd_code),
        .spd_err   (spd_err),
        .empty_err (empty_err),
        .proto_err (proto_err)
    );

    lrx_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .flush     (flush),
        .abort     (abort),
        .dat       (phy_dat),
        .hold_v    (hold_v),
        .pay_vld   (pay_vld),
        .pay_data  (pay_data),
        .pay_first (pay_first),
        .pay_last  (pay_last)
    );

    AST_EMPTY_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err |-> !pay_vld);  // R8
    AST_SPD_NOT_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        spd_vld |-> !pay_vld);  // R3
endmodule

// File: tb/lrx_frame_top_tb.sv
module lrx_frame_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bp_mode = 1'b0;
    logic [1:0] phy_ctl = 2'b00;
    logic [7:0] phy_dat = 8'h00;
    logic       spd_vld, spd_err, pay_vld, pay_first, pay_last, empty_err, proto_err;
    logic [7:0] spd_code, pay_data;

    int tests = 0;
    int fails = 0;

    // bench-side record of what the outputs produced
    logic [7:0] got_d [0:63];
    logic       got_f [0:63];
    logic       got_l [0:63];
    int gcnt = 0, spd_cnt = 0, spderr_cnt = 0, empty_cnt = 0, proto_cnt = 0;
    logic [7:0] last_spd = 8'h00;
    logic mon_en = 1'b0;

    always #4 clk = ~clk;

    lrx_frame_top u_dut (
        .clk(clk), .rst_n(rst_n), .bp_mode(bp_mode), .phy_ctl(phy_ctl),
        .phy_dat(phy_dat), .spd_vld(spd_vld), .spd_code(spd_code),
        .spd_err(spd_err), .pay_vld(pay_vld), .pay_data(pay_data),
        .pay_first(pay_first), .pay_last(pay_last), .empty_err(empty_err),
        .proto_err(proto_err)
    );

    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (pay_vld && gcnt < 64) begin
                got_d[gcnt] = pay_data;
                got_f[gcnt] = pay_first;
                got_l[gcnt] = pay_last;
                gcnt = gcnt + 1;
            end
            if (spd_vld) begin spd_cnt = spd_cnt + 1; last_spd = spd_code; end
            if (spd_err) spderr_cnt = spderr_cnt + 1;
            if (empty_err) empty_cnt = empty_cnt + 1;
            if (proto_err) proto_cnt = proto_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear();
        gcnt = 0; spd_cnt = 0; spderr_cnt = 0; empty_cnt = 0; proto_cnt = 0;
    endtask

    // drive one sample; return just after the edge that takes it
    task automatic cyc(input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        phy_ctl = c;
        phy_dat = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) cyc(2'b00, 8'h00);
    endtask

    // full packet: lead-in, speed code, n bytes starting at base (step 37)
    task automatic send_pkt(input int lead, input logic [7:0] spd, input int n, input logic [7:0] base);
        for (int i = 0; i < lead; i++) cyc(2'b10, 8'hFF);
        cyc(2'b10, spd);
        for (int i = 0; i < n; i++) cyc(2'b10, base + 8'(i * 37));
        idle_n(3);
    endtask

    task automatic chk_stream(input int n, input logic [7:0] base, input logic [7:0] spd);
        chk(gcnt == n, "R5 byte count", gcnt, n);
        chk(spd_cnt == 1, "R3 speed strobes", spd_cnt, 1);
        chk(last_spd == spd, "R3 speed code", last_spd, spd);
        for (int i = 0; i < n && i < gcnt; i++) begin
            logic [7:0] e;
            e = base + 8'(i * 37);
            chk(got_d[i] == e, "R5 byte value", got_d[i], e);
            chk(got_f[i] == (i == 0), "R6 first marker", got_f[i], i == 0);
            chk(got_l[i] == (i == n - 1), "R7 last marker", got_l[i], i == n - 1);
        end
    endtask

    task automatic t_reset();
        chk(!spd_vld && !spd_err && !pay_vld && !pay_first && !pay_last && !empty_err && !proto_err,
            "R1 reset outputs", {spd_vld, spd_err, pay_vld, pay_first, pay_last, empty_err, proto_err}, 0);
    endtask

    task automatic t_timing();
        clear();
        cyc(2'b10, 8'hFF);
        chk(!spd_vld && !pay_vld, "R2 lead-in silent", {spd_vld, pay_vld}, 0);
        cyc(2'b10, 8'h00);
        chk(spd_vld == 1'b1, "R3 speed strobe cycle", spd_vld, 1);
        chk(!pay_vld, "R3 speed not payload", pay_vld, 0);
        cyc(2'b10, 8'hA1);
        chk(!spd_vld && !pay_vld, "R5 first byte held", {spd_vld, pay_vld}, 0);
        cyc(2'b10, 8'hFF);
        chk(pay_vld && pay_data == 8'hA1 && pay_first && !pay_last, "R5 first byte out",
            {pay_vld, pay_first, pay_last, pay_data}, {3'b110, 8'hA1});
        cyc(2'b00, 8'h00);
        chk(pay_vld && pay_data == 8'hFF && !pay_first && pay_last, "R7 last byte out",
            {pay_vld, pay_first, pay_last, pay_data}, {3'b101, 8'hFF});
        cyc(2'b00, 8'h00);
        chk(!pay_vld && !empty_err && !proto_err, "R7 quiet after end", {pay_vld, empty_err, proto_err}, 0);
    endtask

    task automatic t_stream(input int lead, input int n, input logic [7:0] base);
        clear();
        send_pkt(lead, 8'h00, n, base);
        chk_stream(n, base, 8'h00);
        chk(empty_cnt == 0 && proto_cnt == 0, "R5 no errors", empty_cnt + proto_cnt, 0);
    endtask

    task automatic t_speed();
        bp_mode = 1'b1;
        clear(); send_pkt(2, 8'h40, 2, 8'h10);
        chk(spderr_cnt == 1, "R4 bad speed flagged", spderr_cnt, 1);
        clear(); send_pkt(1, 8'h3F, 2, 8'h10);
        chk(spderr_cnt == 0, "R4 low bits allowed", spderr_cnt, 0);
        chk(last_spd == 8'h3F, "R3 speed code kept", last_spd, 8'h3F);
        bp_mode = 1'b0;
        clear(); send_pkt(1, 8'hC0, 2, 8'h10);
        chk(spderr_cnt == 0, "R4 check off", spderr_cnt, 0);
        chk(gcnt == 2, "R5 payload with any speed", gcnt, 2);
    endtask

    task automatic t_empty();
        clear();
        cyc(2'b10, 8'hFF);
        cyc(2'b10, 8'h00);
        cyc(2'b00, 8'h00);
        chk(empty_err == 1'b1 && !pay_vld, "R8 empty pulse", {empty_err, pay_vld}, 2);
        idle_n(2);
        chk(empty_cnt == 1, "R8 single pulse", empty_cnt, 1);
        chk(gcnt == 0, "R8 no payload", gcnt, 0);
    endtask

    task automatic t_proto();
        clear();
        cyc(2'b10, 8'hFF);
        cyc(2'b10, 8'h00);
        cyc(2'b10, 8'h11);
        cyc(2'b10, 8'h22);
        cyc(2'b10, 8'h33);
        cyc(2'b01, 8'h00);
        chk(proto_err == 1'b1, "R9 abort pulse", proto_err, 1);
        idle_n(3);
        chk(proto_cnt == 1, "R9 one pulse", proto_cnt, 1);
        chk(gcnt == 2, "R9 held byte dropped", gcnt, 2);
        chk(gcnt >= 2 && !got_l[0] && !got_l[1], "R9 no last marker", gcnt, 2);
        clear();
        cyc(2'b10, 8'hFF);
        cyc(2'b00, 8'h00);
        chk(proto_err == 1'b1, "R9 idle in lead-in", proto_err, 1);
        idle_n(1);
        clear();
        send_pkt(1, 8'h00, 3, 8'h05);
        chk_stream(3, 8'h05, 8'h00);
    endtask

    task automatic t_wait_ignore();
        clear();
        cyc(2'b01, 8'h00);
        cyc(2'b11, 8'h42);
        cyc(2'b01, 8'hFF);
        idle_n(2);
        chk(gcnt + spd_cnt + empty_cnt + proto_cnt == 0, "R10 other codes ignored",
            gcnt + spd_cnt + empty_cnt + proto_cnt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        idle_n(2);
        t_reset();
        t_timing();
        t_stream(3, 5, 8'h20);
        t_stream(0, 4, 8'hC8);
        t_stream(1, 1, 8'h77);
        t_speed();
        t_empty();
        t_proto();
        t_wait_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule